// File: doc/BRIEF.md
# SHA-2 Message Schedule Expander

This block advances a SHA-2 message schedule by four words per step. Each step takes three 256-bit operand groups, each split into four 64-bit lanes. It produces the next four schedule words W[16..19] from the sixteen words that came before. It serves both the 32-bit word variant, which uses the SHA-256 sigma functions, and the 64-bit word variant, which uses the SHA-512 sigma functions. The 64-bit variant is reachable only when the wide-feature enable is high.

A `start` pulse launches an operation over the element groups from `vstart/4` up to, but not including, `vl/4`. The first group's operands must be on the inputs in the cycle of `start`. Each following cycle must carry the next group's operands. One result is registered per group. The block checks the launch for legality before it writes anything:

- the width code must be allowed,
- `vl` and `vstart` must be group-aligned,
- the destination group must not overlap a source group.

An illegal launch reports a flag and writes no result. There is no per-element mask: every group in range is processed.

Top module: `sha2_sched_expand`

## Requirements
- R1: Lanes are 64 bits wide, and lane k occupies bits [64k+63:64k]. `vd_grp` lanes 0..3 hold W0,W1,W2,W3. `vs2_grp` lanes 0..3 hold W4,W9,W10,W11. `vs1_grp` lanes 0..3 hold W12,W13,W14,W15. Output lanes 0 and 1 carry W16 and W17, where W[t] = s1(W[t-2]) + W[t-7] + s0(W[t-15]) + W[t-16], taken modulo the word size.
- R2: Output lanes 2 and 3 carry W18 and W19. These are computed with the freshly produced W16 and W17 as their s1 arguments.
- R3: Width code `sew`=1 selects 64-bit words. In this mode s0 = ROTR1^ROTR8^SHR7 and s1 = ROTR19^ROTR61^SHR6.
- R4: Width code `sew`=0 selects 32-bit words. In this mode s0 = ROTR7^ROTR18^SHR3 and s1 = ROTR17^ROTR19^SHR10. Only bits [31:0] of each input lane are used, and bits [63:32] of each output lane are zero.
- R5: `sew`=1 with `wide_en` low is illegal. `sew` codes 2 and 3 are always illegal.
- R6: A `vl` or `vstart` value that is not a multiple of 4 is illegal.
- R7: `overlap` high at `start` is illegal.
- R8: After an illegal `start`, `illegal` and `done` are both high one cycle later. In that cycle `res_vld` is low and `res` keeps its previous value.
- R9: A legal operation processes one group per cycle, from group `vstart/4` through group `vl/4-1`. Each result appears one clock after its operands are sampled, with `res_vld` high and `res_grp` giving the group index. `done` rises together with the last result, and `res_vld` falls on the following cycle.
- R10: A legal `start` with `vstart >= vl` raises `done` one cycle later, with no result written.
- R11: A `start` pulse during a running operation abandons that operation and restarts from the new `vstart`.
- R12: After reset, `res` is zero and `res_vld`, `done` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| wide_en | input | 1 | Permits 64-bit words |
| sew | input | 2 | Width code: 0 selects 32-bit, 1 selects 64-bit |
| vl | input | LW | Vector length in elements |
| vstart | input | LW | Start element index |
| overlap | input | 1 | Destination overlaps a source group |
| vd_grp | input | 256 | Words W0..W3 |
| vs2_grp | input | 256 | Words W4, W9, W10, W11 |
| vs1_grp | input | 256 | Words W12..W15 |
| res | output | 256 | W16..W19, with W16 in the lowest lane |
| res_vld | output | 1 | A result was written this cycle |
| res_grp | output | LW-2 | Group index of the current result |
| done | output | 1 | Operation finished |
| illegal | output | 1 | Launch was rejected |

## Verification
Every result is due exactly one clock after the edge that samples its operands. The legality flag and an empty-range `done` are likewise due one clock after `start`. The bench drives operands and `start` at the falling edge and checks the outputs at the next falling edge. For multi-group runs, it swaps in the next group's operands at that same falling edge, so each check pairs with exactly one operand set. One further cycle is checked after the end of every run to confirm that `res_vld` and `done` drop.

// File: rtl/sha2_sched_expand.sv
module sha2_sched_expand #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wide_en,
  input  logic [1:0]    sew,
  input  logic [LW-1:0] vl,
  input  logic [LW-1:0] vstart,
  input  logic          overlap,
  input  logic [255:0]  vd_grp,
  input  logic [255:0]  vs2_grp,
  input  logic [255:0]  vs1_grp,
  output logic [255:0]  res,
  output logic          res_vld,
  output logic [LW-3:0] res_grp,
  output logic          done,
  output logic          illegal
);
  localparam int GW = LW - 2;

  function automatic logic [63:0] fit(input logic m64, input logic [63:0] x);
    return m64 ? x : {32'b0, x[31:0]};
  endfunction

  function automatic logic [63:0] sig0(input logic m64, input logic [63:0] x);
    if (m64) return {x[0], x[63:1]} ^ {x[7:0], x[63:8]} ^ (x >> 7);
    return {32'b0, {x[6:0], x[31:7]} ^ {x[17:0], x[31:18]} ^ (x[31:0] >> 3)};
  endfunction

  function automatic logic [63:0] sig1(input logic m64, input logic [63:0] x);
    if (m64) return {x[18:0], x[63:19]} ^ {x[60:0], x[63:61]} ^ (x >> 6);
    return {32'b0, {x[16:0], x[31:17]} ^ {x[18:0], x[31:19]} ^ (x[31:0] >> 10)};
  endfunction

  logic          busy, m64_q;
  logic [GW-1:0] cur, end_q;

  wire          m_now  = start ? (sew == 2'd1) : m64_q;
  wire          ok     = (vl[1:0] == 2'b00) && (vstart[1:0] == 2'b00) && !overlap &&
                         ((sew == 2'd0) || ((sew == 2'd1) && wide_en));
  wire [GW-1:0] first  = vstart[LW-1:2];
  wire [GW-1:0] endg   = vl[LW-1:2];
  wire          nonemp = first < endg;
  wire [GW-1:0] g_now  = start ? first : cur;
  wire [GW-1:0] e_now  = start ? endg : end_q;
  wire [GW:0]   g_inc  = {1'b0, g_now} + 1'b1;
  wire          last   = (g_inc == {1'b0, e_now});
  wire          proc   = start ? (ok && nonemp) : busy;

  logic [63:0] w0, w1, w2, w3, w4, w9, w10, w11, w12, w13, w14, w15;
  logic [63:0] w16, w17, w18, w19;

  always_comb begin
    w0  = fit(m_now, vd_grp[63:0]);    w1  = fit(m_now, vd_grp[127:64]);
    w2  = fit(m_now, vd_grp[191:128]); w3  = fit(m_now, vd_grp[255:192]);
    w4  = fit(m_now, vs2_grp[63:0]);   w9  = fit(m_now, vs2_grp[127:64]);
    w10 = fit(m_now, vs2_grp[191:128]); w11 = fit(m_now, vs2_grp[255:192]);
    w12 = fit(m_now, vs1_grp[63:0]);   w13 = fit(m_now, vs1_grp[127:64]);
    w14 = fit(m_now, vs1_grp[191:128]); w15 = fit(m_now, vs1_grp[255:192]);
    w16 = fit(m_now, sig1(m_now, w14) + w9  + sig0(m_now, w1) + w0);
    w17 = fit(m_now, sig1(m_now, w15) + w10 + sig0(m_now, w2) + w1);
    w18 = fit(m_now, sig1(m_now, w16) + w11 + sig0(m_now, w3) + w2);
    w19 = fit(m_now, sig1(m_now, w17) + w12 + sig0(m_now, w4) + w3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res     <= '0;
      res_vld <= 1'b0;
      res_grp <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
      busy    <= 1'b0;
      m64_q   <= 1'b0;
      cur     <= '0;
      end_q   <= '0;
    end else begin
      res_vld <= proc;
      illegal <= start && !ok;
      done    <= start ? (!ok || !nonemp || last) : (busy && last);
      if (start) begin
        m64_q <= (sew == 2'd1);
        end_q <= endg;
      end
      if (proc) begin
        res     <= {w19, w18, w17, w16};
        res_grp <= g_now;
        cur     <= g_inc[GW-1:0];
        busy    <= !last;
      end else if (start) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sha2_sched_expand_chk.sv
module sha2_sched_expand_chk #(
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          wide_en,
  input logic [1:0]    sew,
  input logic          overlap,
  input logic [255:0]  res,
  input logic          res_vld,
  input logic [LW-3:0] res_grp,
  input logic          done,
  input logic          illegal,
  input logic          m64_q
);
  p_ill_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!res_vld && done && $stable(res)));

  p_overlap_ill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && overlap) |=> illegal);

  p_wide_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (sew == 2'd1) && !wide_en) |=> illegal);

  p_bad_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && sew[1]) |=> illegal);

  p_vld_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_vld) |-> $past(start));

  p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !res_vld);

  p_grp_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !done && !start) |=> (res_vld && res_grp == $past(res_grp) + 1'b1));

  p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !m64_q) |-> (res[63:32] == 32'd0 && res[127:96] == 32'd0 &&
                             res[191:160] == 32'd0 && res[255:224] == 32'd0));
endmodule

bind sha2_sched_expand sha2_sched_expand_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .wide_en(wide_en), .sew(sew),
  .overlap(overlap), .res(res), .res_vld(res_vld), .res_grp(res_grp),
  .done(done), .illegal(illegal), .m64_q(m64_q)
);

// File: tb/tb_sha2_sched_expand.sv
module tb_sha2_sched_expand;
  localparam int LW = 8;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, wide_en = 1'b0, overlap = 1'b0;
  logic [1:0]    sew = 2'd0;
  logic [LW-1:0] vl = '0, vstart = '0;
  logic [255:0]  vd_grp = '0, vs2_grp = '0, vs1_grp = '0;
  logic [255:0]  res;
  logic          res_vld, done, illegal;
  logic [LW-3:0] res_grp;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sha2_sched_expand #(.LW(LW)) dut (.*);

  function automatic logic [63:0] rr(input logic m64, input logic [63:0] x, input int n);
    if (m64) return (x >> n) | (x << (64 - n));
    return {32'b0, (x[31:0] >> n) | (x[31:0] << (32 - n))};
  endfunction

  function automatic logic [63:0] ls0(input logic m64, input logic [63:0] x);
    return m64 ? (rr(1, x, 1) ^ rr(1, x, 8) ^ (x >> 7))
               : (rr(0, x, 7) ^ rr(0, x, 18) ^ {32'b0, x[31:0] >> 3});
  endfunction

  function automatic logic [63:0] ls1(input logic m64, input logic [63:0] x);
    return m64 ? (rr(1, x, 19) ^ rr(1, x, 61) ^ (x >> 6))
               : (rr(0, x, 17) ^ rr(0, x, 19) ^ {32'b0, x[31:0] >> 10});
  endfunction

  function automatic logic [255:0] model(input logic m64, input logic [255:0] a,
                                         input logic [255:0] b, input logic [255:0] c);
    logic [63:0] w [0:19];
    logic [63:0] mk;
    mk = m64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    for (int k = 0; k < 4; k++) begin
      w[k]    = a[64*k +: 64] & mk;
      w[12+k] = c[64*k +: 64] & mk;
    end
    w[4] = b[63:0] & mk; w[9] = b[127:64] & mk; w[10] = b[191:128] & mk; w[11] = b[255:192] & mk;
    for (int t = 5; t < 9; t++) w[t] = '0;
    for (int t = 16; t < 20; t++)
      w[t] = (ls1(m64, w[t-2]) + w[t-7] + ls0(m64, w[t-15]) + w[t-16]) & mk;
    return {w[19], w[18], w[17], w[16]};
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  logic [255:0] expv;

  task automatic new_ops(input logic m64);
    vd_grp = rnd256(); vs2_grp = rnd256(); vs1_grp = rnd256();
    expv = model(m64, vd_grp, vs2_grp, vs1_grp);
  endtask

  task automatic run(input int vs, input int vlen, input logic [1:0] sw,
                     input logic we, input logic ov, input string tag);
    logic legal;
    int n;
    logic [255:0] prev;
    legal = (vs % 4 == 0) && (vlen % 4 == 0) && !ov && (sw == 0 || (sw == 1 && we));
    n = (legal && vlen > vs) ? (vlen / 4 - vs / 4) : 0;
    @(negedge clk);
    prev = res;
    vstart = LW'(vs); vl = LW'(vlen); sew = sw; wide_en = we; overlap = ov;
    new_ops(sw == 2'd1);
    start = 1'b1;
    if (n == 0) begin
      @(negedge clk);
      start = 1'b0;
      chk({tag, " R8 R10 vld"}, 256'(res_vld), 256'(0));
      chk({tag, " R8 R10 done"}, 256'(done), 256'(1));
      chk({tag, " R5 R6 R7 illegal"}, 256'(illegal), 256'(!legal));
      chk({tag, " R8 res held"}, res, prev);
    end else begin
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R9 vld"}, 256'(res_vld), 256'(1));
        chk({tag, " R1 R2 R3 R4 res"}, res, expv);
        chk({tag, " R9 grp"}, 256'(res_grp), 256'(vs / 4 + i));
        chk({tag, " R9 done"}, 256'(done), 256'(i == n - 1));
        chk({tag, " R9 illegal"}, 256'(illegal), 256'(0));
        new_ops(sw == 2'd1);
      end
    end
    @(negedge clk);
    chk({tag, " R9 tail vld"}, 256'(res_vld), 256'(0));
    chk({tag, " R9 tail done"}, 256'(done), 256'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R12 res", res, '0);
    chk("R12 vld/done/ill", {253'b0, res_vld, done, illegal}, '0);
    rst_n = 1'b1;

    run(0, 4, 2'd0, 1'b0, 1'b0, "dir32");
    run(0, 4, 2'd1, 1'b1, 1'b0, "dir64");
    run(0, 4, 2'd1, 1'b0, 1'b0, "R5 nowide");
    run(0, 4, 2'd2, 1'b1, 1'b0, "R5 code2");
    run(0, 4, 2'd3, 1'b1, 1'b0, "R5 code3");
    run(2, 8, 2'd0, 1'b0, 1'b0, "R6 vstart");
    run(0, 6, 2'd0, 1'b0, 1'b0, "R6 vl");
    run(0, 8, 2'd0, 1'b0, 1'b1, "R7 ovl");
    run(8, 8, 2'd0, 1'b0, 1'b0, "R10 empty");
    run(12, 4, 2'd1, 1'b1, 1'b0, "R10 past");
    run(4, 24, 2'd1, 1'b1, 1'b0, "R9 multi64");

    // R11: restart mid-run
    @(negedge clk);
    vstart = 0; vl = 16; sew = 0; wide_en = 0; overlap = 0;
    new_ops(1'b0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 g0", res, expv);
    new_ops(1'b0);
    @(negedge clk);
    chk("R11 g1 grp", 256'(res_grp), 256'(1));
    vstart = 8; vl = 12; new_ops(1'b0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R11 restart res", res, expv);
    chk("R11 restart grp", 256'(res_grp), 256'(2));
    chk("R11 restart done", 256'(done), 256'(1));
    @(negedge clk);
    chk("R11 stop", 256'(res_vld), 256'(0));

    for (int r = 0; r < 300; r++) begin
      int vs, vlen;
      logic [1:0] sw;
      vs = $urandom % 24;
      vlen = $urandom % 36;
      if ($urandom % 4 != 0) begin vs = vs & ~3; vlen = vlen & ~3; end
      sw = ($urandom % 8 == 0) ? 2'($urandom % 4) : 2'($urandom % 2);
      run(vs, vlen, sw, 1'($urandom), ($urandom % 10 == 0), "rnd");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule